// File: doc/BRIEF.md
# Dual-Half Latch/Register Bus Path

This block carries one direction of a registered bus transceiver. The input port has two halves, each with eight data bits and one parity bit. Every half passes through a storage cell that works in one of three ways, chosen each cycle by the latch-enable level and that half's clock enable:

- **Flow:** the cell is transparent to the input.
- **Capture:** the cell loads the input on the rising clock edge.
- **Hold:** the cell keeps its contents.

The output port is modelled as a data vector plus one drive-enable bit per half, and no tri-state net is used. The opposite direction of a transceiver is a second instance of the same block.

The clock, the latch enable and the active-low output enable are shared by both halves. Each half has its own active-low clock enable, sampled on the rising clock edge like the data. While the latch enable is high, the stored value follows the input on every edge. When the latch enable falls, the cell therefore keeps the input seen at the last edge before the fall. An asynchronous active-low reset clears every stored bit.

Top module: `univ_bus_path`

## Requirements
- R1: While oe_ni is 1, b_drive_o is 2'b00 and b_data_o is all zero, whatever the other inputs are.
- R2: While oe_ni is 0, both bits of b_drive_o are 1.
- R3: While le_i is 1 and oe_ni is 0, b_data_o equals a_data_i in the same cycle, with no clock edge needed.
- R4: While le_i is 0 and cken_ni[h] is 0, a rising clk_i edge stores half h of a_data_i, and that value appears on b_data_o after the edge.
- R5: While le_i is 0 and cken_ni[h] is 1, half h keeps its stored value across clock edges.
- R6: The clock enables of the two halves act independently. Half h occupies bits h*9+8 down to h*9, and a capture in one half leaves the other half unchanged.
- R7: After le_i falls, the output keeps the input value sampled at the last rising edge while le_i was 1, until a capture occurs.
- R8: rst_ni low clears both stored halves to zero at once, without a clock edge.
- R9: The parity bit of each half (bits 8 and 17) is stored and passed exactly like the data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| le_i | input | 1 | Latch enable: 1 selects flow, 0 selects register/hold |
| oe_ni | input | 1 | Active-low output enable |
| cken_ni | input | 2 | Active-low clock enable, one bit per half |
| a_data_i | input | 18 | Input port, two halves of 8 data bits plus parity |
| b_data_o | output | 18 | Output port value (zero when not driven) |
| b_drive_o | output | 2 | Drive enable per half; 0 means high impedance |

## Verification
A sweep walks all sixteen combinations of latch enable, output enable and the two clock enables. Each combination is tried with all-zero, all-one and two alternating data patterns, so flow, capture, hold and high impedance can each be told apart on every bit.

A long random sequence of control and data follows, with the output checked against a per-half model both before and after every edge. Directed cases separate the two halves on mixed clock enables and confirm the value left after the latch enable falls. They also check that parity bits are stored and that reset clears the cells with no clock edge.

// File: rtl/ubp_pkg.sv
`timescale 1ns/1ps
package ubp_pkg;

  typedef enum logic [1:0] {
    MODE_FLOW    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_HOLD    = 2'd2
  } cell_mode_e;

  // latch enable dominates; clock enable only matters in register mode
  function automatic cell_mode_e decode_mode(input logic le, input logic cken_n);
    if (le)          return MODE_FLOW;
    else if (!cken_n) return MODE_CAPTURE;
    else             return MODE_HOLD;
  endfunction

endpackage

// File: rtl/ubp_cell.sv
`timescale 1ns/1ps
module ubp_cell
  import ubp_pkg::*;
#(
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic             cken_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] y_o
);

  cell_mode_e       mode;
  logic [WIDTH-1:0] q;

  assign mode = decode_mode(le_i, cken_ni);

  // flow mode also loads, so a falling latch enable keeps the last sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= '0;
    else if (mode != MODE_HOLD) q <= d_i;
  end

  always_comb begin
    y_o = (mode == MODE_FLOW) ? d_i : q;
  end

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !cken_ni) |=> (q == $past(d_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && cken_ni) |=> $stable(q));

  assert_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q == $past(d_i)));

endmodule

// File: rtl/ubp_out_stage.sv
`timescale 1ns/1ps
module ubp_out_stage #(
  parameter int unsigned HALVES = 2,
  parameter int unsigned HALF_W = 9,
  localparam int unsigned BUS_W = HALVES * HALF_W
) (
  input  logic              oe_ni,
  input  logic [BUS_W-1:0]  y_i,
  output logic [BUS_W-1:0]  data_o,
  output logic [HALVES-1:0] drive_o
);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_comb begin
      drive_o[h]                  = ~oe_ni;
      data_o[h*HALF_W +: HALF_W]  = oe_ni ? '0 : y_i[h*HALF_W +: HALF_W];
    end
  end

endmodule

// File: rtl/univ_bus_path.sv
`timescale 1ns/1ps
module univ_bus_path #(
  parameter int unsigned HALVES = 2,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HALF_W = DATA_W + 1,
  localparam int unsigned BUS_W  = HALVES * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              oe_ni,
  input  logic [HALVES-1:0] cken_ni,
  input  logic [BUS_W-1:0]  a_data_i,
  output logic [BUS_W-1:0]  b_data_o,
  output logic [HALVES-1:0] b_drive_o
);

  logic [BUS_W-1:0] cell_y;

  for (genvar h = 0; h < HALVES; h++) begin : g_cell
    ubp_cell #(.WIDTH(HALF_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .le_i    (le_i),
      .cken_ni (cken_ni[h]),
      .d_i     (a_data_i[h*HALF_W +: HALF_W]),
      .y_o     (cell_y[h*HALF_W +: HALF_W])
    );

    assert_half_isolated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!le_i && cken_ni[h] && !oe_ni) ##1 (!le_i && !oe_ni)
      |-> $stable(b_data_o[h*HALF_W +: HALF_W]));
  end

  ubp_out_stage #(.HALVES(HALVES), .HALF_W(HALF_W)) u_out (
    .oe_ni   (oe_ni),
    .y_i     (cell_y),
    .data_o  (b_data_o),
    .drive_o (b_drive_o)
  );

  assert_hiz_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (b_drive_o == '0 && b_data_o == '0));

  assert_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> (&b_drive_o));

  assert_flow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && !oe_ni) |-> (b_data_o == a_data_i));

endmodule

// File: tb/univ_bus_path_test.sv
`timescale 1ns/1ps
module univ_bus_path_test;

  localparam int HW = 9;
  localparam int BW = 18;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          le_i = 1'b0;
  logic          oe_ni = 1'b1;
  logic [1:0]    cken_ni = 2'b11;
  logic [BW-1:0] a_data_i = '0;
  logic [BW-1:0] b_data_o;
  logic [1:0]    b_drive_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [HW-1:0] mq [2];

  always #2.5 clk = ~clk;

  univ_bus_path uut (
    .clk_i(clk), .rst_ni(rst_ni), .le_i(le_i), .oe_ni(oe_ni),
    .cken_ni(cken_ni), .a_data_i(a_data_i),
    .b_data_o(b_data_o), .b_drive_o(b_drive_o)
  );

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_out();
    for (int h = 0; h < 2; h++) begin
      logic [HW-1:0] e;
      string tag;
      if (oe_ni)            begin e = '0;                       tag = "R1"; end
      else if (le_i)        begin e = a_data_i[h*HW +: HW];     tag = "R3"; end
      else if (!cken_ni[h]) begin e = mq[h];                    tag = "R4"; end
      else                  begin e = mq[h];                    tag = "R5"; end
      chk(tag, {9'd0, b_data_o[h*HW +: HW]}, {9'd0, e});
    end
    chk(oe_ni ? "R1" : "R2", {16'd0, b_drive_o}, {16'd0, oe_ni ? 2'b00 : 2'b11});
  endtask

  task automatic step(input logic le, input logic oe, input logic [1:0] ckn, input logic [BW-1:0] d);
    @(negedge clk);
    le_i = le; oe_ni = oe; cken_ni = ckn; a_data_i = d;
    #1;
    expect_out();
    @(posedge clk);
    for (int h = 0; h < 2; h++)
      if (le || !ckn[h]) mq[h] = d[h*HW +: HW];
    #1;
    expect_out();
  endtask

  function automatic logic [BW-1:0] pattern(input int k);
    case (k)
      0: return 18'h00000;
      1: return 18'h3FFFF;
      2: return 18'h2AAAA;
      default: return 18'h15555;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    mq[0] = '0; mq[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    oe_ni = 1'b0; le_i = 1'b0;
    #1;
    chk("R8", b_data_o, '0);            // reset state
    chk("R2", {16'd0, b_drive_o}, 18'd3);
    rst_ni = 1'b1;

    // sweep every control combination over four data patterns
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 4; k++)
        step(c[3], c[2], c[1:0], pattern(k) ^ {c[3:0], 14'h0});

    // R6: half 0 captures, half 1 holds
    step(1'b0, 1'b0, 2'b00, 18'h3FFFF);
    step(1'b0, 1'b0, 2'b10, 18'h00000);
    chk("R6", b_data_o, {9'h1FF, 9'h000});
    step(1'b0, 1'b0, 2'b01, 18'h00000);
    chk("R6", b_data_o, 18'h00000);

    // R7: value sampled at last edge while latch enable high survives its fall
    step(1'b1, 1'b0, 2'b11, 18'h0A5C3);
    step(1'b0, 1'b0, 2'b11, 18'h35A3C);
    chk("R7", b_data_o, 18'h0A5C3);

    // R9: parity bits alone are stored and held
    step(1'b0, 1'b0, 2'b00, 18'h20100);
    step(1'b0, 1'b0, 2'b11, 18'h00000);
    chk("R9", b_data_o, 18'h20100);

    // R8: asynchronous clear with no clock edge
    step(1'b0, 1'b0, 2'b00, 18'h3FFFF);
    @(negedge clk);
    cken_ni = 2'b11;
    rst_ni = 1'b0;
    #1;
    chk("R8", b_data_o, 18'h00000);
    mq[0] = '0; mq[1] = '0;
    @(negedge clk);
    rst_ni = 1'b1;

    // random control and data sequence
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[3] & r[2], (r[1:0] == 2'b11), 2'($urandom), 18'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule